// File: doc/BRIEF.md
# Cascadable Phase Accumulator with Load Latency and Start-Up Sequencing

This block keeps a 32-bit phase word that wraps modulo 2^32. On every clock it adds the active increment and a one-bit external carry. The output frequency is f_out = f_clk × increment / 2^32. The upper phase bits drive a downstream waveform stage. A registered carry-out is provided, so that two instances can be chained into a wider accumulator: the lower stage's carry-out feeds the upper stage's carry-in.

A new increment is captured on a load strobe. It becomes active only after a fixed pipeline latency, and phase continuity is kept because the accumulator is never disturbed. An active-low sync output marks, for one cycle, the moment the new increment takes effect. The same pulse also appears at a fixed distance after reset is released.

Reset is synchronous and active-low. After release the block runs a start-up sequence. It presents a code that the waveform stage substitutes for its own output (00h, then 80h, then 81h), and it holds the phase at zero until normal accumulation resumes.

Top module: `nco_phase_core`

## Requirements
- R1: In normal operation, each rising edge sets the phase to (phase + active increment + cin) mod 2^32. `phase_hi` is bits 31..20 of the phase.
- R2: With `cin` = 1, each edge advances the phase by one more than the active increment.
- R3: `cout` is high for the single cycle that follows an edge whose sum exceeded 2^32 − 1, and is low otherwise.
- R4: A load captured at edge E (`ld` = 1) makes `inc_in` the active increment at edge E+34. The first edge that adds it is E+35. The phase is not disturbed at the switch.
- R5: `sync_n` is low for exactly one cycle, the cycle after edge E+34 of a load.
- R6: `sync_n` is low for one cycle, the cycle after the 35th rising edge following reset release.
- R7: While `rst_n` is low at an edge, the phase is cleared, `cout` is 0, `warm_code` is 00h, `warm_active` is 1 and `sync_n` is 1. Loads are ignored.
- R8: After release, `warm_code` is 00h after edge 1, 80h after edge 2 and 81h after edges 3 to 37. `warm_active` is high through edge 37 and falls after edge 38, with the phase at zero. `warm_code` reads 00h in normal operation.
- R9: A load that arrives before an earlier load has taken effect replaces it and restarts the 34-edge count. Only one sync pulse results, timed from the later load.
- R10: Reset discards a load still waiting to take effect, but keeps the active increment. After start-up, the phase advances with the increment that was active before reset.
- R11: During start-up the phase stays zero and `cout` stays low, whatever `cin` and the increment are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld | input | 1 | Load strobe, sampled on each edge |
| inc_in | input | 32 | Increment captured by a load |
| cin | input | 1 | Carry from a lower-order stage |
| phase_hi | output | 12 | Upper 12 bits of the phase |
| cout | output | 1 | Overflow of the last addition |
| sync_n | output | 1 | Active-low one-cycle marker of a frequency switch or start-up point |
| warm_active | output | 1 | High while the start-up sequence runs |
| warm_code | output | 8 | Substitute waveform code during start-up |

## Verification
The sync output has two sources that can fall in the same cycle. A load captured on the first edge after reset release completes its 34-edge latency in exactly the cycle where the start-up marker falls. The bench provokes this by raising the strobe together with the release. It requires a single low cycle, at edge 35, and no second pulse. It also confirms that the loaded increment drives the phase once start-up ends. A reference model compares every output every cycle against the expected trace.

// File: rtl/nco_pkg.sv
// Package: shared defaults and the start-up stage type for the phase core.
// Assumes consumers take widths as parameters and use these only as defaults.
package nco_pkg;
    localparam int ACC_W_DEF      = 32;
    localparam int OUT_W_DEF      = 12;
    localparam int LOAD_LAT_DEF   = 34;
    localparam int WARM_EDGES_DEF = 37;
    localparam int SYNC_EDGE_DEF  = 35;
    localparam int CODE_W_DEF     = 8;

    // Start-up stages in the order they are visited after reset release.
    typedef enum logic [1:0] {
        WS_CLEAR = 2'd0,
        WS_MID   = 2'd1,
        WS_ZERO  = 2'd2,
        WS_RUN   = 2'd3
    } warm_stage_e;
endpackage

// File: rtl/nco_warmup.sv
// Start-up sequencer: counts edges after reset release, saturates once
// normal operation begins, and flags the start-up sync point.
// Assumes WARM_EDGES > SYNC_EDGE > 2.
module nco_warmup
    import nco_pkg::*;
#(
    parameter int WARM_EDGES = WARM_EDGES_DEF,
    parameter int SYNC_EDGE  = SYNC_EDGE_DEF
) (
    input  logic        clk,
    input  logic        rst_n,
    output warm_stage_e stage,
    output logic        rst_sync,
    output logic        run
);
    localparam int DONE = WARM_EDGES + 1;
    localparam int CW   = $clog2(DONE + 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(DONE);
    localparam logic [CW-1:0] CNT_SYNC = CW'(SYNC_EDGE);
    localparam logic [CW-1:0] CNT_MID  = CW'(2);

    logic [CW-1:0] cnt;

    // Edge counter since release, frozen once the run state is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != CNT_DONE)
            cnt <= cnt + 1'b1;
    end

    // Stage decode and start-up markers.
    always_comb begin
        run      = (cnt == CNT_DONE);
        rst_sync = (cnt == CNT_SYNC);
        if (cnt < CNT_MID)       stage = WS_CLEAR;
        else if (cnt == CNT_MID) stage = WS_MID;
        else if (!run)           stage = WS_ZERO;
        else                     stage = WS_RUN;
    end

    // R8
    warm_run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    // R7
    warm_release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stage == WS_CLEAR));
endmodule

// File: rtl/nco_freq_loader.sv
// Increment loader: captures a new increment on a load strobe, counts the
// fixed latency, then swaps it into the active increment and flags it.
// Assumes LOAD_LAT >= 2. The active and pending increments survive reset.
module nco_freq_loader #(
    parameter int ACC_W    = nco_pkg::ACC_W_DEF,
    parameter int LOAD_LAT = nco_pkg::LOAD_LAT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [ACC_W-1:0] inc_in,
    output logic [ACC_W-1:0] inc_act,
    output logic             fire_q
);
    localparam int CDW = $clog2(LOAD_LAT + 1);
    localparam logic [CDW-1:0] CD_START = CDW'(LOAD_LAT);
    localparam logic [CDW-1:0] CD_LAST  = CDW'(1);

    logic [CDW-1:0]   cd;
    logic [ACC_W-1:0] pend;
    logic             fire;

    // A reload in the swap cycle wins over the pending swap.
    assign fire = (cd == CD_LAST) && !ld;

    // Latency countdown and the registered swap marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd     <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= fire;
            if (ld)
                cd <= CD_START;
            else if (cd != '0)
                cd <= cd - 1'b1;
        end
    end

    // Pending increment capture, ignored while reset is held.
    always_ff @(posedge clk) begin
        if (rst_n && ld)
            pend <= inc_in;
    end

    // Active increment swap at the end of the latency.
    always_ff @(posedge clk) begin
        if (rst_n && fire)
            inc_act <= pend;
    end

    // R4
    inc_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> (inc_act == $past(pend)));

    // R5
    swap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);
endmodule

// File: rtl/nco_phase_acc.sv
// Phase accumulator: modulo 2^ACC_W sum of the phase, the active increment
// and an external carry, with a registered overflow flag. It advances only
// while run is high and otherwise holds its value.
module nco_phase_acc #(
    parameter int ACC_W = nco_pkg::ACC_W_DEF,
    parameter int OUT_W = nco_pkg::OUT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] inc,
    input  logic             cin,
    output logic [OUT_W-1:0] phase_hi,
    output logic             cout
);
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc;
    logic [SUM_W-1:0] sum;

    // Full-width sum; its top bit is the overflow.
    assign sum = {1'b0, acc} + {1'b0, inc} + SUM_W'(cin);

    // Phase register and carry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            cout <= 1'b0;
        end else if (run) begin
            {cout, acc} <= sum;
        end else begin
            cout <= 1'b0;
        end
    end

    assign phase_hi = acc[ACC_W-1 -: OUT_W];

    // R3
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cout |-> (acc <= $past(acc)));

    // R3
    wrap_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run) && (acc < $past(acc))) |-> cout);
endmodule

// File: rtl/nco_phase_core.sv
// Top: phase accumulator with latency-delayed increment loads, an active-low
// sync marker and the start-up code sequence. The waveform lookup and the
// register bus live outside this block.
module nco_phase_core
    import nco_pkg::*;
#(
    parameter int ACC_W      = ACC_W_DEF,
    parameter int OUT_W      = OUT_W_DEF,
    parameter int LOAD_LAT   = LOAD_LAT_DEF,
    parameter int WARM_EDGES = WARM_EDGES_DEF,
    parameter int SYNC_EDGE  = SYNC_EDGE_DEF,
    parameter int CODE_W     = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ACC_W-1:0]  inc_in,
    input  logic              cin,
    output logic [OUT_W-1:0]  phase_hi,
    output logic              cout,
    output logic              sync_n,
    output logic              warm_active,
    output logic [CODE_W-1:0] warm_code
);
    localparam logic [CODE_W-1:0] CODE_MID  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_HOLD = CODE_MID + CODE_W'(1);

    warm_stage_e      stage;
    logic             rst_sync;
    logic             run;
    logic [ACC_W-1:0] inc_act;
    logic             fire_q;

    nco_warmup #(
        .WARM_EDGES (WARM_EDGES),
        .SYNC_EDGE  (SYNC_EDGE)
    ) u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage    (stage),
        .rst_sync (rst_sync),
        .run      (run)
    );

    nco_freq_loader #(
        .ACC_W    (ACC_W),
        .LOAD_LAT (LOAD_LAT)
    ) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (ld),
        .inc_in  (inc_in),
        .inc_act (inc_act),
        .fire_q  (fire_q)
    );

    nco_phase_acc #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .inc      (inc_act),
        .cin      (cin),
        .phase_hi (phase_hi),
        .cout     (cout)
    );

    // Merge the two sync sources into one active-low marker.
    assign sync_n      = !(fire_q || rst_sync);
    assign warm_active = (stage != WS_RUN);

    // Map the start-up stage to the substitute waveform code.
    always_comb begin
        unique case (stage)
            WS_MID:  warm_code = CODE_MID;
            WS_ZERO: warm_code = CODE_HOLD;
            default: warm_code = '0;
        endcase
    end

    // R11
    warm_phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_active |-> ((phase_hi == '0) && !cout));

    // R6
    warm_sync_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && warm_active) |-> (warm_code == CODE_HOLD));

    // R7
    release_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((phase_hi == '0) && (warm_code == '0) && sync_n));
endmodule

// File: tb/tb_nco_phase_core.sv
module tb_nco_phase_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld = 1'b0;
    logic [31:0] inc_in = '0;
    logic        cin = 1'b0;
    logic [11:0] phase_hi;
    logic        cout;
    logic        sync_n;
    logic        warm_active;
    logic [7:0]  warm_code;

    int checks = 0;
    int errors = 0;
    string section = "reset";

    always #2 clk = ~clk;

    nco_phase_core dut (
        .clk(clk), .rst_n(rst_n), .ld(ld), .inc_in(inc_in), .cin(cin),
        .phase_hi(phase_hi), .cout(cout), .sync_n(sync_n),
        .warm_active(warm_active), .warm_code(warm_code)
    );

    typedef struct packed {
        logic [11:0] ph;
        logic        co;
        logic        sn;
        logic        wa;
        logic [7:0]  wc;
    } exp_t;
    exp_t sbq[$];

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s [%s]: got %h expected %h", req, what, section, got, exp);
        end
    endtask

    // Reference model: expected port state after each edge, pushed to the scoreboard.
    int          m_rel = 0;
    logic [31:0] m_acc = '0;
    logic [31:0] m_inc = '0;
    logic [31:0] m_pend = '0;
    int          m_cd = 0;
    logic        m_fire = 1'b0;
    logic        m_carry = 1'b0;
    always @(posedge clk) begin
        logic [32:0] s;
        logic        fire_now;
        exp_t        e;
        if (!rst_n) begin
            m_rel = 0; m_acc = '0; m_cd = 0; m_fire = 1'b0; m_carry = 1'b0;
        end else begin
            if (m_rel == 38) begin
                s = {1'b0, m_acc} + {1'b0, m_inc} + {32'd0, cin};
                m_carry = s[32];
                m_acc = s[31:0];
            end else begin
                m_carry = 1'b0;
            end
            fire_now = (m_cd == 1) && !ld;
            if (fire_now) m_inc = m_pend;
            if (ld) begin
                m_pend = inc_in; m_cd = 34;
            end else if (m_cd != 0) begin
                m_cd = m_cd - 1;
            end
            m_fire = fire_now;
            if (m_rel != 38) m_rel = m_rel + 1;
        end
        e.ph = m_acc[31:20];
        e.co = m_carry;
        e.sn = !(m_fire || (m_rel == 35));
        e.wa = (m_rel != 38);
        e.wc = (m_rel <= 1) ? 8'h00 : (m_rel == 2) ? 8'h80 : (m_rel < 38) ? 8'h81 : 8'h00;
        sbq.push_back(e);
    end

    // Monitor: compare each cycle's outputs with the next expected item.
    always @(negedge clk) begin
        exp_t e;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            check("R1", "phase_hi", 32'(phase_hi), 32'(e.ph));
            check("R3", "cout", 32'(cout), 32'(e.co));
            check("R5/R6", "sync_n", 32'(sync_n), 32'(e.sn));
            check("R8", "warm_active", 32'(warm_active), 32'(e.wa));
            check("R8", "warm_code", 32'(warm_code), 32'(e.wc));
        end
    end

    task automatic do_load(logic [31:0] v);
        ld = 1'b1; inc_in = v;
        @(negedge clk);
        ld = 1'b0;
    endtask

    // Wait for sync low; k = edges after the load edge, prev = phase a cycle before.
    task automatic wait_sync(output int k, output logic [11:0] prev);
        logic [11:0] last;
        last = phase_hi;
        k = 0;
        prev = last;
        for (int i = 1; i <= 80; i++) begin
            @(negedge clk);
            if (!sync_n) begin
                k = i; prev = last; break;
            end
            last = phase_hi;
        end
    endtask

    logic [31:0] lfsr = 32'h1D2C_3B4A;
    function automatic logic [31:0] next_rand(logic [31:0] x);
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    bit done = 1'b0;
    initial begin
        int k, lows, lowpos, wafall, nz, cnt;
        logic [11:0] prev, p0, p1;
        repeat (4) @(negedge clk);
        // R7: outputs held in reset
        check("R7", "phase_hi", 32'(phase_hi), 32'h0);
        check("R7", "warm_code", 32'(warm_code), 32'h0);
        check("R7", "warm_active", 32'(warm_active), 32'h1);
        check("R7", "sync_n", 32'(sync_n), 32'h1);
        check("R7", "cout", 32'(cout), 32'h0);

        // Release with a load on edge 1: load sync meets start-up sync (R5, R6, R11).
        section = "R6 coincide";
        rst_n = 1'b1; ld = 1'b1; inc_in = 32'h0030_0000; cin = 1'b1;
        lows = 0; lowpos = 0; wafall = 0; nz = 0;
        for (int i = 1; i <= 45; i++) begin
            @(negedge clk);
            if (i == 1) ld = 1'b0;
            if (i == 37) cin = 1'b0;
            if (!sync_n) begin lows++; lowpos = i; end
            if (!warm_active && wafall == 0) wafall = i;
            if (i <= 38 && (phase_hi != 0 || cout)) nz++;
            if (i == 1) check("R8", "code edge1", 32'(warm_code), 32'h00);
            if (i == 2) check("R8", "code edge2", 32'(warm_code), 32'h80);
            if (i == 37) check("R8", "code edge37", 32'(warm_code), 32'h81);
        end
        check("R6", "sync low count", lows, 1);
        check("R6", "sync low edge", lowpos, 35);
        check("R8", "warm_active fall edge", wafall, 38);
        check("R11", "phase/cout activity in start-up", nz, 0);
        check("R1", "phase after start-up", 32'(phase_hi), 32'h015);

        // R2: carry-in adds one to the increment.
        section = "R2";
        do_load(32'h000F_FFFF); cin = 1'b1;
        wait_sync(k, prev);
        check("R5", "load-to-sync edges", k, 34);
        check("R4", "old step at switch", 32'(phase_hi - prev), 32'h003);
        p0 = phase_hi;
        @(negedge clk); p1 = phase_hi;
        check("R2", "step with cin", 32'(p1 - p0), 32'h001);
        @(negedge clk);
        check("R2", "second step with cin", 32'(phase_hi - p1), 32'h001);
        cin = 1'b0;
        repeat (2) @(negedge clk);

        // R3: half-range increment overflows every other edge.
        section = "R3";
        do_load(32'h8000_0000);
        wait_sync(k, prev);
        check("R5", "load-to-sync edges", k, 34);
        p0 = phase_hi;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i == 0) check("R4", "new step after switch", 32'(phase_hi - p0), 32'h800);
            if (cout) cnt++;
        end
        check("R3", "carry pulses in 10 edges", cnt, 5);

        // R9: a second load restarts the latency.
        section = "R9";
        ld = 1'b1; inc_in = 32'h0050_0000;
        lows = 0; lowpos = 0;
        for (int i = 1; i <= 50; i++) begin
            @(negedge clk);
            if (i == 1) ld = 1'b0;
            if (i == 10) begin ld = 1'b1; inc_in = 32'h0020_0000; end
            if (i == 11) ld = 1'b0;
            if (!sync_n) begin lows++; lowpos = i; end
            if (i == 45) p0 = phase_hi;
            if (i == 47) check("R9", "step of later load", 32'(phase_hi - p0), 32'h004);
        end
        check("R9", "sync low count", lows, 1);
        check("R9", "sync low edge", lowpos, 45);

        // R10: reset drops the waiting load but keeps the active increment.
        section = "R10";
        do_load(32'h0070_0000);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7", "phase in reset", 32'(phase_hi), 32'h0);
        check("R7", "cout in reset", 32'(cout), 32'h0);
        rst_n = 1'b1;
        lows = 0; lowpos = 0;
        for (int i = 1; i <= 45; i++) begin
            @(negedge clk);
            if (!sync_n) begin lows++; lowpos = i; end
        end
        check("R10", "sync low count", lows, 1);
        check("R10", "sync low edge", lowpos, 35);
        check("R10", "phase with retained increment", 32'(phase_hi), 32'h00E);

        // Pseudo-random increments and carry-in, judged by the scoreboard.
        section = "R1 random";
        for (int n = 0; n < 6; n++) begin
            lfsr = next_rand(lfsr);
            do_load(lfsr);
            for (int i = 0; i < 40; i++) begin
                lfsr = next_rand(lfsr);
                cin = lfsr[7];
                @(negedge clk);
            end
        end
        cin = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule